// File: doc/BRIEF.md
# Dual-Master Interrupt Status Controller

This block holds the interrupt state for a downstream bus segment that two upstream masters share. Each master has its own 8-bit status register and its own active-low interrupt line. Four kinds of cause can set a status bit. The first is a downstream interrupt request, which can be masked per master. The second is a master's self-test bit. The third is a test bit that one master aims at the other. The fourth is a set of one-cycle event pulses from the bus-switching engine: the master lost ownership, the bus was busy at the switch, or recovery has finished.

The status bits clear in two ways. The test bits and the downstream-request bit follow their cause, and a read leaves them untouched. The three event bits clear during a read of that master's register, on the second clock pulse of the read phase. The read is presented as a per-master read-enable level together with a per-pulse tick. Each interrupt line is low whenever its master's register holds any set bit, so it can drive an open-drain pad enable directly.

Top module: `dual_master_irq_sel`

## Requirements
- R1: Synchronous active-low reset clears both status registers and the synchronizer, and leaves both interrupt outputs high.
- R2: The downstream request `dsIrqN` is active low and passes through a two-flop synchronizer. Its status bit (bit 0) becomes 1 on the third rising edge after `dsIrqN` goes low. That master's `irqN` goes low at the same time.
- R3: While `intMask[m]` is 1, bit 0 of master m's register is 0 from the next edge, and the downstream request cannot pull `irqN[m]` low.
- R4: `selfTest[m]` at 1 sets bit 6 of master m's register on the next edge and pulls `irqN[m]` low. Returning it to 0 clears bit 6 on the next edge.
- R5: `peerTest[m]` at 1 sets bit 7 in the other master's register on the next edge and pulls that master's interrupt low. Returning it to 0 clears that bit.
- R6: A read does not clear bits 7, 6 or 0. Bit 0 stays set while the synchronized request is active and unmasked. It clears three edges after `dsIrqN` returns high.
- R7: On the edge that samples an event pulse for master m, the matching bit in m's register is set:
  - `evtLost[m]` sets bit 3.
  - `evtBusy[m]` sets bit 2, but only while `recReq[m]` is 0.
  - `evtInit[m]` sets bit 1.
- R8: The read phase and its clear work as follows:
  - Ticks are counted only while `rdEn[m]` is 1, and the count restarts when `rdEn[m]` drops.
  - Bits 3..1 of master m's register clear on the edge that samples the second `rdTick[m]` of the read.
  - A first tick, ticks with `rdEn[m]` at 0, and a tick count restarted by dropping `rdEn[m]` all leave the bits unchanged.
- R9: An event pulse that arrives on the clearing edge wins, and its bit stays set.
- R10: A read by one master leaves the other master's register unchanged.
- R11: Bits 5 and 4 always read 0. `irqN[m]` is 0 exactly when master m's register is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| dsIrqN | input | 1 | Downstream interrupt request, active low, asynchronous |
| intMask | input | 2 | Per-master mask for the downstream request |
| selfTest | input | 2 | Per-master self-test interrupt request |
| peerTest | input | 2 | Per-master test interrupt aimed at the other master |
| evtLost | input | 2 | Pulse: this master lost bus ownership |
| evtBusy | input | 2 | Pulse: bus not idle when switched to this master |
| evtInit | input | 2 | Pulse: bus recovery finished |
| recReq | input | 2 | Recovery requested; suppresses the busy event |
| rdEn | input | 2 | Per-master status read in progress |
| rdTick | input | 2 | One pulse per clock pulse of the read phase |
| stat0 | output | 8 | Status register of master 0 |
| stat1 | output | 8 | Status register of master 1 |
| irqN | output | 2 | Per-master interrupt output, active low |

## Verification
Results from the test bits, the mask, the event pulses and the read clear are due one rising edge after the stimulus. Results that depend on `dsIrqN` are due three edges after it changes: two synchronizer stages and then the status register. Every stimulus is applied on a falling edge. The bench then waits exactly the due number of rising edges and samples on the next falling edge, and each vector in the table carries its own edge count. The read-clear tests also sample after the first tick, to show the clear has not happened early, and drive an event pulse on the very edge that clears.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NUM_M  = 2;
  localparam int STAT_W = 8;
  // bit positions inside each status register
  localparam int B_PEER = 7;
  localparam int B_SELF = 6;
  localparam int B_LOST = 3;
  localparam int B_BUSY = 2;
  localparam int B_INIT = 1;
  localparam int B_EXT  = 0;

  typedef struct packed {
    logic             extActive;
    logic [NUM_M-1:0] clrEvt;
    logic [NUM_M-1:0] setLost;
    logic [NUM_M-1:0] setBusy;
    logic [NUM_M-1:0] setInit;
  } ctrl_strb_t;
endpackage

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLR_TICK    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dsIrqN,
  input  logic [NUM_M-1:0] evtLost,
  input  logic [NUM_M-1:0] evtBusy,
  input  logic [NUM_M-1:0] evtInit,
  input  logic [NUM_M-1:0] recReq,
  input  logic [NUM_M-1:0] rdEn,
  input  logic [NUM_M-1:0] rdTick,
  output ctrl_strb_t       strb
);
  localparam int CNT_W = $clog2(CLR_TICK + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [NUM_M-1:0]       clrVec;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], ~dsIrqN};
  end

  for (genvar g = 0; g < NUM_M; g++) begin : g_rd
    logic [CNT_W-1:0] tickCnt;

    always_ff @(posedge clk) begin
      if (!rstN || !rdEn[g])                          tickCnt <= '0;
      else if (rdTick[g] && tickCnt != CNT_W'(CLR_TICK)) tickCnt <= tickCnt + 1'b1;
    end

    assign clrVec[g] = rdEn[g] & rdTick[g] & (tickCnt == CNT_W'(CLR_TICK - 1));

    // the opening tick of a read never clears
    assert_first_tick_no_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(rdEn[g]) && rdTick[g]) |-> !clrVec[g]);
  end

  always_comb begin
    strb.extActive = syncQ[SYNC_STAGES-1];
    strb.clrEvt    = clrVec;
    strb.setLost   = evtLost;
    strb.setBusy   = evtBusy & ~recReq;
    strb.setInit   = evtInit;
  end
endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp
  import irq_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strb_t       strb,
  input  logic [NUM_M-1:0] intMask,
  input  logic [NUM_M-1:0] selfTest,
  input  logic [NUM_M-1:0] peerTest,
  output logic [NUM_M-1:0][STAT_W-1:0] statAll,
  output logic [NUM_M-1:0] irqN
);
  for (genvar g = 0; g < NUM_M; g++) begin : g_reg
    localparam int OTH = NUM_M - 1 - g;
    logic [STAT_W-1:0] regQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ <= '0;
      end else begin
        regQ[B_PEER]  <= peerTest[OTH];
        regQ[B_SELF]  <= selfTest[g];
        regQ[5:4]     <= 2'b00;
        regQ[B_LOST]  <= (regQ[B_LOST] & ~strb.clrEvt[g]) | strb.setLost[g];
        regQ[B_BUSY]  <= (regQ[B_BUSY] & ~strb.clrEvt[g]) | strb.setBusy[g];
        regQ[B_INIT]  <= (regQ[B_INIT] & ~strb.clrEvt[g]) | strb.setInit[g];
        regQ[B_EXT]   <= strb.extActive & ~intMask[g];
      end
    end

    assign statAll[g] = regQ;
    assign irqN[g]    = ~|regQ;

    assert_self_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
      selfTest[g] |=> !irqN[g]);
    assert_peer_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
      peerTest[OTH] |=> regQ[B_PEER]);
    assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
      intMask[g] |=> !regQ[B_EXT]);
    assert_ext_survives_R6: assert property (@(posedge clk) disable iff (!rstN)
      (regQ[B_EXT] && strb.extActive && !intMask[g]) |=> regQ[B_EXT]);
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
      strb.setLost[g] |=> regQ[B_LOST]);
    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrEvt[g] && !strb.setLost[g] && !strb.setBusy[g] && !strb.setInit[g])
        |=> (regQ[B_LOST:B_INIT] == 3'b000));
  end
endmodule

// File: rtl/dual_master_irq_sel.sv
module dual_master_irq_sel
  import irq_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLR_TICK    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dsIrqN,
  input  logic [1:0] intMask,
  input  logic [1:0] selfTest,
  input  logic [1:0] peerTest,
  input  logic [1:0] evtLost,
  input  logic [1:0] evtBusy,
  input  logic [1:0] evtInit,
  input  logic [1:0] recReq,
  input  logic [1:0] rdEn,
  input  logic [1:0] rdTick,
  output logic [7:0] stat0,
  output logic [7:0] stat1,
  output logic [1:0] irqN
);
  ctrl_strb_t strb;
  logic [NUM_M-1:0][STAT_W-1:0] statAll;

  irq_sel_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CLR_TICK(CLR_TICK)) ctrl_i (
    .clk(clk), .rstN(rstN), .dsIrqN(dsIrqN),
    .evtLost(evtLost), .evtBusy(evtBusy), .evtInit(evtInit), .recReq(recReq),
    .rdEn(rdEn), .rdTick(rdTick), .strb(strb)
  );

  irq_sel_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .intMask(intMask),
    .selfTest(selfTest), .peerTest(peerTest), .statAll(statAll), .irqN(irqN)
  );

  assign stat0 = statAll[0];
  assign stat1 = statAll[1];
endmodule

// File: tb/dual_master_irq_sel_tb.sv
module dual_master_irq_sel_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic dsIrqN;
  logic [1:0] intMask, selfTest, peerTest, evtLost, evtBusy, evtInit, recReq, rdEn, rdTick;
  logic [7:0] stat0, stat1;
  logic [1:0] irqN;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_master_irq_sel dut_i (
    .clk(clk), .rstN(rstN), .dsIrqN(dsIrqN), .intMask(intMask),
    .selfTest(selfTest), .peerTest(peerTest), .evtLost(evtLost),
    .evtBusy(evtBusy), .evtInit(evtInit), .recReq(recReq),
    .rdEn(rdEn), .rdTick(rdTick), .stat0(stat0), .stat1(stat1), .irqN(irqN)
  );

  // fields: ds, mask, self, peer, lost, busy, init, rec, edges, exp0, exp1
  localparam logic [34:0] VEC [9] = '{
    {1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 4'd1, 8'h00, 8'h00}, // idle
    {1'b1, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 4'd1, 8'h40, 8'h00}, // R4
    {1'b1, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 4'd1, 8'h00, 8'h80}, // R4 clear, R5
    {1'b1, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 4'd1, 8'h80, 8'h00}, // R5
    {1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 4'd3, 8'h01, 8'h00}, // R2 R3
    {1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 4'd1, 8'h01, 8'h01}, // R3 unmask
    {1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 4'd3, 8'h00, 8'h00}, // R6
    {1'b1, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 2'b00, 4'd1, 8'h08, 8'h04}, // R7
    {1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b01, 4'd1, 8'h08, 8'h06}  // R7 suppress
  };

  task automatic checkState(input string req, input logic [7:0] e0, input logic [7:0] e1);
    logic [1:0] eIrq;
    eIrq = {~|e1, ~|e0};
    checks++;
    if (stat0 !== e0 || stat1 !== e1) begin
      errors++;
      $display("FAIL %s: status %h/%h expected %h/%h", req, stat0, stat1, e0, e1);
    end
    checks++;
    if (irqN !== eIrq) begin
      errors++;
      $display("FAIL R11 (%s): irqN %b expected %b", req, irqN, eIrq);
    end
  endtask

  task automatic edgeThen();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; dsIrqN = 1'b1;
    {intMask, selfTest, peerTest, evtLost, evtBusy, evtInit, recReq, rdEn, rdTick} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkState("R1 reset", 8'h00, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      {dsIrqN, intMask, selfTest, peerTest, evtLost, evtBusy, evtInit, recReq} = VEC[i][34:20];
      repeat (int'(VEC[i][19:16])) @(posedge clk);
      @(negedge clk);
      evtLost = '0; evtBusy = '0; evtInit = '0;
      checkState($sformatf("vector %0d (R2 R3 R4 R5 R6 R7)", i), VEC[i][15:8], VEC[i][7:0]);
    end
    recReq = '0;

    // R8 / R10: read of master 1, clear on second tick only
    rdEn = 2'b10; rdTick = 2'b10;
    edgeThen(); rdTick = 2'b00;
    checkState("R8 first tick keeps", 8'h08, 8'h06);
    edgeThen();
    checkState("R8 gap keeps", 8'h08, 8'h06);
    rdTick = 2'b10;
    edgeThen(); rdTick = 2'b00; rdEn = 2'b00;
    checkState("R8 R10 second tick clears", 8'h08, 8'h00);

    // R6: level bits survive a read
    selfTest = 2'b01; dsIrqN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkState("R2 R4 levels set", 8'h49, 8'h01);
    rdEn = 2'b01; rdTick = 2'b01;
    edgeThen();
    edgeThen(); rdTick = 2'b00; rdEn = 2'b00;
    checkState("R6 read keeps level bits", 8'h41, 8'h01);
    edgeThen(); edgeThen();
    checkState("R6 request stays raised", 8'h41, 8'h01);

    // R9: event on the clearing edge wins
    rdEn = 2'b01; rdTick = 2'b01;
    edgeThen();
    evtLost = 2'b01; evtInit = 2'b01;
    edgeThen(); evtLost = '0; evtInit = '0; rdTick = '0; rdEn = '0;
    checkState("R9 event beats clear", 8'h4B, 8'h01);

    // R8: dropping rdEn restarts the count; ticks without rdEn ignored
    rdEn = 2'b01; rdTick = 2'b01;
    edgeThen(); rdEn = 2'b00; rdTick = 2'b00;
    edgeThen(); rdEn = 2'b01; rdTick = 2'b01;
    edgeThen(); rdEn = 2'b00;
    edgeThen(); rdTick = 2'b00;
    checkState("R8 restart and idle ticks keep", 8'h4B, 8'h01);

    // R6 / R4: causes removed
    dsIrqN = 1'b1; selfTest = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkState("R6 R4 causes gone", 8'h0A, 8'h00);

    // R1: reset in mid-run
    rstN = 1'b0;
    edgeThen();
    checkState("R1 mid-run reset", 8'h00, 8'h00);
    rstN = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule